// File: doc/BRIEF.md
# Serial Controller Bus Strobe Adapter

This block joins a host processor bus to a dual-channel serial communications controller. The controller accepts its bus strobes on two shared pins. On a controller with a multiplexed address/data bus, these pins carry an address strobe and a data strobe. On a controller with separate address and data buses, they carry a write strobe and a read strobe. The block chooses between the two modes at run time. It watches a sense input that sees the host's address latch enable: if pulses appear there, the controller is taken to be multiplexed, and if the input stays low, it is taken to be non-multiplexed.

The block also follows the host's two-cycle interrupt acknowledge. It gives the controller an address strobe only in the first acknowledge cycle and a data strobe only in the second. It forces both strobe pins active while reset is held, and it decodes the host address into chip enable, channel select and data/command select. It also makes a clipped copy of the controller's transmit DMA request, which goes inactive as soon as the host starts writing channel B's data register.

Every output is registered and follows its inputs by one clock.

Top module: `scc_bus_glue`

## Requirements
- R1: While `rst` is high, the next clock drives both strobe pins low (asserted), `ce_n` high and `dreq_clip_n` high. Reset also returns the block to non-multiplexed mode and to the first acknowledge cycle.
- R2: A rising edge on `ale_sense` selects multiplexed mode from that clock onward. After IDLE_LIMIT clocks (default 32) with no new rising edge, the block falls back to non-multiplexed mode.
- R3: In multiplexed mode, `strb_a_n` is low for each clock in which `ale_sense` was high at the previous edge. `strb_b_n` is low when a read or a write is made to a selected register.
- R4: In non-multiplexed mode, `strb_b_n` follows a selected read with one clock of latency. `strb_a_n` follows a selected write, but only once `wr_n` has been low for WR_DELAY clocks (default 1).
- R5: The write strobe on `strb_a_n` goes high on the first clock at which `wr_n` is seen high. It never outlasts the host write.
- R6: An interrupt acknowledge is two low periods of `inta_n`, and the cycle counter advances when each one ends. In the first cycle only the address strobe may go out. In the second cycle `strb_b_n` is low while `inta_n` is low, and `strb_a_n` stays high even if `ale_sense` pulses.
- R7: If the second acknowledge cycle has not started ACK_LIMIT clocks (default 16) after the first one ended, the tracker returns to the first-cycle state.
- R8: A register is selected only when `cs_n` is low and `addr[0]` is 0. `addr[2:1]` picks the register: 0 is channel B command, 1 is channel B data, 2 is channel A command, 3 is channel A data. `ch_a_sel` equals `addr[2]` and `data_sel` equals `addr[1]`, both one clock later, and `ce_n` is low one clock after a selection.
- R9: Address bits 6:3 have no effect, so the four registers repeat every 8 bytes across the 128-byte window.
- R10: `dreq_clip_n` follows `txreq_n`, but goes high from the clock after a write to channel B data is seen. It stays high until `txreq_n` has gone high, and it is never low while `txreq_n` was high.
- R11: Outside reset, the two strobe pins are never low at the same time. When both are requested, `strb_b_n` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| ale_sense | input | 1 | Address latch enable sense; tied low for a non-multiplexed controller |
| cs_n | input | 1 | Host window select, active low |
| addr | input | 7 | Host byte address inside the 128-byte window |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| inta_n | input | 1 | Host interrupt acknowledge cycle status, active low |
| txreq_n | input | 1 | Controller's raw transmit DMA request, active low |
| strb_a_n | output | 1 | Shared pin A: address strobe or delayed write strobe |
| strb_b_n | output | 1 | Shared pin B: data strobe or read strobe |
| ce_n | output | 1 | Controller chip enable, active low |
| ch_a_sel | output | 1 | 1 selects channel A, 0 selects channel B |
| data_sel | output | 1 | 1 selects the data register, 0 the command register |
| dreq_clip_n | output | 1 | Clipped transmit DMA request, active low |

## Verification
A wrong mode flag shows up on the first write after it goes wrong: the strobe appears on the wrong pin, in the clock after the write is seen. A stale acknowledge phase suppresses the address strobe of the next ALE pulse, or lets it through when it should be blocked, one clock after that pulse. A bad write-delay counter moves the falling edge of `strb_a_n` earlier or later by whole clocks. A clip flag that fails to clear keeps `dreq_clip_n` high through the next request cycle.

// File: rtl/scc_glue_pkg.sv
package scc_glue_pkg;

    typedef enum logic {
        MODE_SEPARATE = 1'b0,
        MODE_MUXED    = 1'b1
    } bus_mode_e;

    typedef enum logic {
        ACK_FIRST  = 1'b0,
        ACK_SECOND = 1'b1
    } ack_phase_e;

    typedef struct packed {
        logic hit;
        logic chan_a;
        logic data;
    } reg_sel_t;

    typedef struct packed {
        logic a_n;
        logic b_n;
    } strobe_pair_t;

    // Only the low three address bits matter; higher bits alias.
    function automatic reg_sel_t decode_reg(input logic cs_n, input logic [2:0] low);
        reg_sel_t s;
        s.hit    = ~cs_n & ~low[0];
        s.chan_a = low[2];
        s.data   = low[1];
        return s;
    endfunction

endpackage

// File: rtl/glue_mode_detect.sv
module glue_mode_detect
    import scc_glue_pkg::*;
#(
    parameter int IDLE_LIMIT = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ale_sense,
    output bus_mode_e mode,
    output logic      ale_rise
);
    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_LIMIT - 1);

    logic             ale_d;
    logic [CNT_W-1:0] idle_cnt;

    assign ale_rise = ale_sense & ~ale_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_d    <= 1'b0;
            idle_cnt <= '0;
            mode     <= MODE_SEPARATE;
        end else begin
            ale_d <= ale_sense;
            if (ale_rise) begin
                mode     <= MODE_MUXED;
                idle_cnt <= '0;
            end else if (mode == MODE_MUXED) begin
                if (idle_cnt == LAST) begin
                    mode     <= MODE_SEPARATE;
                    idle_cnt <= '0;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/glue_ack_track.sv
module glue_ack_track
    import scc_glue_pkg::*;
#(
    parameter int ACK_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       inta_n,
    output ack_phase_e phase
);
    localparam int CNT_W = $clog2(ACK_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_LIMIT - 1);

    logic             inta_d_n;
    logic             cycle_end;
    logic [CNT_W-1:0] wait_cnt;

    assign cycle_end = inta_n & ~inta_d_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            inta_d_n <= 1'b1;
            wait_cnt <= '0;
            phase    <= ACK_FIRST;
        end else begin
            inta_d_n <= inta_n;
            if (cycle_end) begin
                phase    <= (phase == ACK_FIRST) ? ACK_SECOND : ACK_FIRST;
                wait_cnt <= '0;
            end else if (phase == ACK_SECOND && inta_n) begin
                if (wait_cnt == LAST) begin
                    phase    <= ACK_FIRST;
                    wait_cnt <= '0;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end else begin
                wait_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/glue_strobe_gen.sv
module glue_strobe_gen
    import scc_glue_pkg::*;
#(
    parameter int WR_DELAY = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_mode_e    mode_now,
    input  ack_phase_e   phase,
    input  logic         ale_sense,
    input  logic         hit,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic         inta_n,
    output strobe_pair_t strb
);
    localparam int DLY_W = $clog2(WR_DELAY + 2);
    localparam logic [DLY_W-1:0] DLY_MAX = DLY_W'(WR_DELAY);

    logic             muxed;
    logic             sep_write;
    logic             ack_data;
    logic             write_ripe;
    logic             b_req;
    logic             a_req;
    logic [DLY_W-1:0] wr_cnt;

    assign muxed      = (mode_now == MODE_MUXED);
    assign sep_write  = ~muxed & hit & ~wr_n;
    assign ack_data   = (phase == ACK_SECOND) & ~inta_n;
    assign write_ripe = sep_write & (wr_cnt >= DLY_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt <= '0;
        end else if (sep_write) begin
            wr_cnt <= (wr_cnt == DLY_MAX) ? wr_cnt : wr_cnt + 1'b1;
        end else begin
            wr_cnt <= '0;
        end
    end

    always_comb begin
        b_req = ack_data | (hit & (~rd_n | (muxed & ~wr_n)));
        a_req = (ale_sense & (phase == ACK_FIRST)) | write_ripe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strb <= '{a_n: 1'b0, b_n: 1'b0};
        end else begin
            strb.b_n <= ~b_req;
            strb.a_n <= ~(a_req & ~b_req);
        end
    end
endmodule

// File: rtl/glue_dma_clip.sv
module glue_dma_clip (
    input  logic clk,
    input  logic rst,
    input  logic txreq_n,
    input  logic bdata_wr,
    output logic dreq_clip_n
);
    logic clipped;

    always_ff @(posedge clk) begin
        if (rst) begin
            clipped     <= 1'b0;
            dreq_clip_n <= 1'b1;
        end else begin
            if (txreq_n) begin
                clipped <= 1'b0;
            end else if (bdata_wr) begin
                clipped <= 1'b1;
            end
            dreq_clip_n <= txreq_n | clipped | bdata_wr;
        end
    end
endmodule

// File: rtl/scc_bus_glue.sv
module scc_bus_glue
    import scc_glue_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int IDLE_LIMIT = 32,
    parameter int ACK_LIMIT  = 16,
    parameter int WR_DELAY   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_sense,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              inta_n,
    input  logic              txreq_n,
    output logic              strb_a_n,
    output logic              strb_b_n,
    output logic              ce_n,
    output logic              ch_a_sel,
    output logic              data_sel,
    output logic              dreq_clip_n
);
    bus_mode_e    mode;
    bus_mode_e    mode_now;
    logic         ale_rise;
    ack_phase_e   phase;
    reg_sel_t     sel;
    strobe_pair_t strb;
    logic         bdata_wr;
    logic         unused_hi;

    assign unused_hi = ^addr[ADDR_W-1:3];
    assign sel       = decode_reg(cs_n, addr[2:0]);
    assign mode_now  = ale_rise ? MODE_MUXED : mode;
    assign bdata_wr  = sel.hit & ~sel.chan_a & sel.data & ~wr_n;

    glue_mode_detect #(.IDLE_LIMIT(IDLE_LIMIT)) u_mode (
        .clk(clk), .rst(rst), .ale_sense(ale_sense),
        .mode(mode), .ale_rise(ale_rise)
    );

    glue_ack_track #(.ACK_LIMIT(ACK_LIMIT)) u_ack (
        .clk(clk), .rst(rst), .inta_n(inta_n), .phase(phase)
    );

    glue_strobe_gen #(.WR_DELAY(WR_DELAY)) u_strb (
        .clk(clk), .rst(rst), .mode_now(mode_now), .phase(phase),
        .ale_sense(ale_sense), .hit(sel.hit), .rd_n(rd_n), .wr_n(wr_n),
        .inta_n(inta_n), .strb(strb)
    );

    glue_dma_clip u_clip (
        .clk(clk), .rst(rst), .txreq_n(txreq_n), .bdata_wr(bdata_wr),
        .dreq_clip_n(dreq_clip_n)
    );

    assign strb_a_n = strb.a_n;
    assign strb_b_n = strb.b_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_n     <= 1'b1;
            ch_a_sel <= 1'b0;
            data_sel <= 1'b0;
        end else begin
            ce_n     <= ~sel.hit;
            ch_a_sel <= sel.chan_a;
            data_sel <= sel.data;
        end
    end
endmodule

// File: rtl/scc_bus_glue_chk.sv
module scc_bus_glue_chk (
    input logic       clk,
    input logic       rst,
    input logic       ale_sense,
    input logic       cs_n,
    input logic [2:0] addr_lo,
    input logic       wr_n,
    input logic       inta_n,
    input logic       txreq_n,
    input logic       strb_a_n,
    input logic       strb_b_n,
    input logic       ce_n,
    input logic       ch_a_sel,
    input logic       data_sel,
    input logic       dreq_clip_n
);
    AST_RESET_FORCES_STROBES: assert property (@(posedge clk)
        rst |=> (!strb_a_n && !strb_b_n && ce_n && dreq_clip_n)); // R1

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !(!strb_a_n && !strb_b_n)); // R11

    AST_WRITE_NOT_EXTENDED: assert property (@(posedge clk) disable iff (rst)
        (wr_n && !ale_sense) |=> strb_a_n); // R5

    AST_ODD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (addr_lo[0] && inta_n) |=> (ce_n && strb_b_n)); // R8

    AST_DECODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !addr_lo[0]) |=>
            (!ce_n && ch_a_sel == $past(addr_lo[2]) && data_sel == $past(addr_lo[1]))); // R8

    AST_CLIP_NOT_AHEAD: assert property (@(posedge clk) disable iff (rst)
        txreq_n |=> dreq_clip_n); // R10
endmodule

bind scc_bus_glue scc_bus_glue_chk u_chk (
    .clk(clk), .rst(rst), .ale_sense(ale_sense), .cs_n(cs_n),
    .addr_lo(addr[2:0]), .wr_n(wr_n), .inta_n(inta_n), .txreq_n(txreq_n),
    .strb_a_n(strb_a_n), .strb_b_n(strb_b_n), .ce_n(ce_n),
    .ch_a_sel(ch_a_sel), .data_sel(data_sel), .dreq_clip_n(dreq_clip_n)
);

// File: tb/tb_scc_bus_glue.sv
`timescale 1ns/1ps
module tb_scc_bus_glue;
    localparam int IDLE = 32;
    localparam int ACKL = 16;
    localparam int WRD  = 1;
    localparam int NVEC = 9;

    // {cs_n, addr[6:0], rd_n, exp_b_n, exp_ce_n, exp_ch, exp_dc}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b0, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {1'b0, 7'h02, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 7'h04, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b0, 7'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b0, 7'h7E, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b0, 7'h4A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {1'b0, 7'h03, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {1'b1, 7'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b0, 7'h7C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst, ale_sense, cs_n, rd_n, wr_n, inta_n, txreq_n;
    logic [6:0] addr;
    logic strb_a_n, strb_b_n, ce_n, ch_a_sel, data_sel, dreq_clip_n;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    scc_bus_glue #(.ADDR_W(7), .IDLE_LIMIT(IDLE), .ACK_LIMIT(ACKL), .WR_DELAY(WRD)) dut (
        .clk(clk), .rst(rst), .ale_sense(ale_sense), .cs_n(cs_n), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .txreq_n(txreq_n),
        .strb_a_n(strb_a_n), .strb_b_n(strb_b_n), .ce_n(ce_n),
        .ch_a_sel(ch_a_sel), .data_sel(data_sel), .dreq_clip_n(dreq_clip_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_bus();
        ale_sense = 1'b0; cs_n = 1'b1; addr = '0;
        rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle_bus();
        txreq_n = 1'b1;
        rst = 1'b1;
        tick(); tick();
        chk("R1", "reset strb_a_n", strb_a_n, 1'b0);
        chk("R1", "reset strb_b_n", strb_b_n, 1'b0);
        chk("R1", "reset ce_n", ce_n, 1'b1);
        chk("R1", "reset dreq", dreq_clip_n, 1'b1);
        rst = 1'b0;
        tick();
        chk("R1", "idle strb_a_n", strb_a_n, 1'b1);
        chk("R1", "idle strb_b_n", strb_b_n, 1'b1);

        // R8 R9 R4: decode and read strobes, non-multiplexed
        for (int i = 0; i < NVEC; i++) begin
            cs_n = VEC[i][12]; addr = VEC[i][11:5]; rd_n = VEC[i][4];
            tick();
            chk("R4", $sformatf("vec%0d strb_b_n", i), strb_b_n, VEC[i][3]);
            chk("R11", $sformatf("vec%0d strb_a_n", i), strb_a_n, 1'b1);
            chk("R8", $sformatf("vec%0d ce_n", i), ce_n, VEC[i][2]);
            chk("R9", $sformatf("vec%0d ch_a_sel", i), ch_a_sel, VEC[i][1]);
            chk("R9", $sformatf("vec%0d data_sel", i), data_sel, VEC[i][0]);
        end
        idle_bus(); tick();

        // R4 R5: delayed write
        cs_n = 1'b0; addr = 7'h02; wr_n = 1'b0;
        tick(); chk("R4", "write held off", strb_a_n, 1'b1);
        tick(); chk("R4", "write strobe on", strb_a_n, 1'b0);
        tick(); chk("R4", "write strobe held", strb_a_n, 1'b0);
        chk("R4", "no read during write", strb_b_n, 1'b1);
        wr_n = 1'b1;
        tick(); chk("R5", "write strobe ends", strb_a_n, 1'b1);
        idle_bus(); tick();

        // R11: both requested
        cs_n = 1'b0; addr = 7'h00; rd_n = 1'b0; wr_n = 1'b0;
        tick(); tick();
        chk("R11", "read wins b", strb_b_n, 1'b0);
        chk("R11", "read wins a", strb_a_n, 1'b1);
        idle_bus(); tick();

        // R2 R3: multiplexed mode
        ale_sense = 1'b1;
        tick(); chk("R3", "address strobe", strb_a_n, 1'b0);
        ale_sense = 1'b0;
        tick(); chk("R3", "address strobe ends", strb_a_n, 1'b1);
        cs_n = 1'b0; addr = 7'h06; wr_n = 1'b0;
        tick(); chk("R3", "mux write on b", strb_b_n, 1'b0);
        chk("R3", "mux write not on a", strb_a_n, 1'b1);
        wr_n = 1'b1;
        tick(); chk("R3", "mux write ends", strb_b_n, 1'b1);
        rd_n = 1'b0;
        tick(); chk("R3", "mux read on b", strb_b_n, 1'b0);
        idle_bus();
        repeat (20) tick();
        cs_n = 1'b0; wr_n = 1'b0;
        tick(); chk("R2", "mode kept before limit", strb_b_n, 1'b0);
        idle_bus();
        repeat (IDLE + 2) tick();
        cs_n = 1'b0; wr_n = 1'b0;
        tick(); chk("R2", "fallback delays write", strb_a_n, 1'b1);
        chk("R2", "fallback b idle", strb_b_n, 1'b1);
        tick(); chk("R2", "fallback write on a", strb_a_n, 1'b0);
        idle_bus(); tick();

        // R6: acknowledge in multiplexed mode
        ale_sense = 1'b1;
        tick(); chk("R6", "first cycle AS", strb_a_n, 1'b0);
        ale_sense = 1'b0; inta_n = 1'b0;
        tick(); chk("R6", "first cycle no DS", strb_b_n, 1'b1);
        inta_n = 1'b1; tick();
        ale_sense = 1'b1;
        tick(); chk("R6", "second cycle no AS", strb_a_n, 1'b1);
        ale_sense = 1'b0; inta_n = 1'b0;
        tick(); chk("R6", "second cycle DS", strb_b_n, 1'b0);
        inta_n = 1'b1;
        tick(); chk("R6", "second cycle DS ends", strb_b_n, 1'b1);
        ale_sense = 1'b1;
        tick(); chk("R6", "back to first", strb_a_n, 1'b0);
        ale_sense = 1'b0; tick();

        // R7: acknowledge watchdog
        ale_sense = 1'b1; tick();
        ale_sense = 1'b0; inta_n = 1'b0; tick();
        inta_n = 1'b1; tick();
        repeat (ACKL + 2) tick();
        ale_sense = 1'b1;
        tick(); chk("R7", "watchdog restores first", strb_a_n, 1'b0);
        ale_sense = 1'b0;
        repeat (IDLE + 2) tick();

        // R6: acknowledge in non-multiplexed mode
        inta_n = 1'b0;
        tick(); chk("R6", "sep first cycle no read", strb_b_n, 1'b1);
        inta_n = 1'b1; tick();
        inta_n = 1'b0;
        tick(); chk("R6", "sep second cycle read", strb_b_n, 1'b0);
        inta_n = 1'b1;
        tick(); chk("R6", "sep second ends", strb_b_n, 1'b1);

        // R10: clipped DMA request
        txreq_n = 1'b0;
        tick(); chk("R10", "dreq follows", dreq_clip_n, 1'b0);
        cs_n = 1'b0; addr = 7'h06; wr_n = 1'b0;
        tick(); chk("R10", "chan A write no clip", dreq_clip_n, 1'b0);
        wr_n = 1'b1; tick();
        addr = 7'h02; wr_n = 1'b0;
        tick(); chk("R10", "chan B data write clips", dreq_clip_n, 1'b1);
        idle_bus();
        tick(); chk("R10", "clip held", dreq_clip_n, 1'b1);
        txreq_n = 1'b1;
        tick(); chk("R10", "raw inactive", dreq_clip_n, 1'b1);
        txreq_n = 1'b0;
        tick(); chk("R10", "re-armed", dreq_clip_n, 1'b0);
        txreq_n = 1'b1; tick();

        // R1: reset mid-operation clears multiplexed mode
        ale_sense = 1'b1; tick();
        ale_sense = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
        rst = 1'b1;
        tick(); chk("R1", "reset overrides a", strb_a_n, 1'b0);
        chk("R1", "reset overrides b", strb_b_n, 1'b0);
        chk("R1", "reset ce_n", ce_n, 1'b1);
        rst = 1'b0; idle_bus();
        tick();
        cs_n = 1'b0; wr_n = 1'b0;
        tick(); chk("R1", "mode cleared a", strb_a_n, 1'b1);
        chk("R1", "mode cleared b", strb_b_n, 1'b1);
        tick(); chk("R1", "mode cleared write on a", strb_a_n, 1'b0);
        idle_bus(); tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule